// File: doc/BRIEF.md
# Synchronized Clock Fanout Controller

The block takes one of two input clocks, picked by a select pin, and drives two banks of clock outputs from it. The full-rate bank carries the selected clock gated by an output enable. The half-rate bank carries the output of a toggle stage that the selected clock drives. Every output within a bank comes from one shared source, so the banks stay matched. The default split is ten outputs per bank.

An active-low hold input passes through a shift register that the falling edge of the selected clock drives. A change on the hold input reaches the output enable only after a fixed count of falling edges. When the enable drops, every output is low. When it rises again, the toggle stage starts from a known state, so the first half-rate pulse begins on the same rising edge as the first full-rate pulse. An asynchronous active-low reset clears the shift register and the toggle stage. The mux between the two clocks is a plain selection, so a change of the select while the outputs run may glitch them.

Top module: `clk_fanout_ctl`

## Requirements
- R1: With `src_sel_i` = 1 the full-rate outputs follow `diff_clk_i`. With `src_sel_i` = 0 they follow `se_clk_i`. This holds while `out_en_o` is 1.
- R2: While `arst_ni` is 0, `out_en_o` and every bit of both output banks are 0, whatever the clocks and `hold_ni` do.
- R3: After `hold_ni` goes low, `out_en_o` goes low exactly at the fourth falling edge of the selected clock that samples it low. From then on, all outputs stay low.
- R4: After `hold_ni` goes high, and after `arst_ni` is released with `hold_ni` high, `out_en_o` goes high exactly at the fourth falling edge of the selected clock that samples it high.
- R5: The first rising edge of the selected clock after `out_en_o` rises drives every half-rate output high, together with the full-rate outputs.
- R6: While `out_en_o` stays high, the half-rate outputs change level on every rising edge of the selected clock.
- R7: While `out_en_o` is 1, every full-rate output equals the selected clock. While it is 0, every full-rate output is 0.
- R8: All outputs in one bank carry the same level at all times.
- R9: A low pulse on `hold_ni` that is sampled by a single falling edge drops `out_en_o` for exactly one clock period, four falling edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| diff_clk_i | input | 1 | Clock source picked when the select is 1 |
| se_clk_i | input | 1 | Clock source picked when the select is 0 |
| src_sel_i | input | 1 | Source select |
| arst_ni | input | 1 | Asynchronous reset, active low |
| hold_ni | input | 1 | Output hold request, active low |
| out_en_o | output | 1 | Output enable as seen by the banks |
| full_clk_o | output | N_FULL | Full-rate clock outputs |
| half_clk_o | output | N_HALF | Half-rate clock outputs |

## Verification
A wrong value anywhere in the falling-edge shift chain moves the enable edge off its expected falling edge. The enable port shows this at most four falling edges after the bad value entered. A toggle stage that leaves its hold state wrongly shows up at the first rising edge after release, as a half-rate output that starts low. A lost toggle shows up as two equal half-rate levels on consecutive rising edges. Because the full-rate bank is gated by the same enable, an enable fault also shows as a missing or extra full-rate pulse in the same clock period.

// File: rtl/cfo_pkg.sv
`timescale 1ns/100ps
package cfo_pkg;
  // falling edges between a hold change and the enable change
  localparam int unsigned SYNC_STAGES = 4;
  localparam int unsigned DEF_FULL    = 10;
  localparam int unsigned DEF_HALF    = 10;
endpackage

// File: rtl/cfo_src_mux.sv
`timescale 1ns/100ps
module cfo_src_mux (
  input  logic a_clk_i,
  input  logic b_clk_i,
  input  logic sel_a_i,
  output logic clk_o
);
  always_comb begin
    clk_o = sel_a_i ? a_clk_i : b_clk_i;
  end
endmodule

// File: rtl/cfo_hold_sync.sv
`timescale 1ns/100ps
module cfo_hold_sync #(
  parameter int unsigned DEPTH = cfo_pkg::SYNC_STAGES
) (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic hold_ni,
  output logic en_o
);
  localparam int unsigned MSB = DEPTH - 1;

  logic [MSB:0] chain_q;
  logic [MSB:0] chain_d;

  always_comb begin
    chain_d = {chain_q[MSB-1:0], hold_ni};
  end

  always_ff @(negedge clk_i or negedge arst_ni) begin
    if (!arst_ni) chain_q <= '0;
    else          chain_q <= chain_d;
  end

  assign en_o = chain_q[MSB];
endmodule

// File: rtl/cfo_half_div.sv
`timescale 1ns/100ps
module cfo_half_div (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic en_i,
  output logic half_o
);
  logic tgl_q;
  logic tgl_d;

  // held at zero while disabled so the first toggle after release is high
  always_comb begin
    tgl_d = en_i ? ~tgl_q : 1'b0;
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) tgl_q <= 1'b0;
    else          tgl_q <= tgl_d;
  end

  assign half_o = tgl_q;
endmodule

// File: rtl/cfo_out_bank.sv
`timescale 1ns/100ps
module cfo_out_bank #(
  parameter int unsigned WIDTH = 1
) (
  input  logic             src_i,
  input  logic             en_i,
  output logic [WIDTH-1:0] out_o
);
  logic gated;

  always_comb begin
    gated = src_i & en_i;
  end

  for (genvar g = 0; g < WIDTH; g++) begin : g_drv
    assign out_o[g] = gated;
  end
endmodule

// File: rtl/clk_fanout_ctl.sv
`timescale 1ns/100ps
module clk_fanout_ctl #(
  parameter int unsigned N_FULL = cfo_pkg::DEF_FULL,
  parameter int unsigned N_HALF = cfo_pkg::DEF_HALF
) (
  input  logic              diff_clk_i,
  input  logic              se_clk_i,
  input  logic              src_sel_i,
  input  logic              arst_ni,
  input  logic              hold_ni,
  output logic              out_en_o,
  output logic [N_FULL-1:0] full_clk_o,
  output logic [N_HALF-1:0] half_clk_o
);
  logic clk_sel;
  logic en;
  logic half_src;

  cfo_src_mux u_mux (
    .a_clk_i (diff_clk_i),
    .b_clk_i (se_clk_i),
    .sel_a_i (src_sel_i),
    .clk_o   (clk_sel)
  );

  cfo_hold_sync #(.DEPTH(cfo_pkg::SYNC_STAGES)) u_sync (
    .clk_i   (clk_sel),
    .arst_ni (arst_ni),
    .hold_ni (hold_ni),
    .en_o    (en)
  );

  cfo_half_div u_div (
    .clk_i   (clk_sel),
    .arst_ni (arst_ni),
    .en_i    (en),
    .half_o  (half_src)
  );

  cfo_out_bank #(.WIDTH(N_FULL)) u_full (
    .src_i (clk_sel),
    .en_i  (en),
    .out_o (full_clk_o)
  );

  cfo_out_bank #(.WIDTH(N_HALF)) u_half (
    .src_i (half_src),
    .en_i  (en),
    .out_o (half_clk_o)
  );

  assign out_en_o = en;
endmodule

// File: rtl/clk_fanout_ctl_chk.sv
`timescale 1ns/100ps
module clk_fanout_ctl_chk #(
  parameter int unsigned N_FULL = cfo_pkg::DEF_FULL,
  parameter int unsigned N_HALF = cfo_pkg::DEF_HALF
) (
  input logic              clk_sel,
  input logic              arst_ni,
  input logic              hold_ni,
  input logic              out_en_o,
  input logic [N_FULL-1:0] full_clk_o,
  input logic [N_HALF-1:0] half_clk_o
);
  logic [2:0] fall_cnt;
  logic       warm;

  always_ff @(negedge clk_sel or negedge arst_ni) begin
    if (!arst_ni)          fall_cnt <= '0;
    else if (fall_cnt < 4) fall_cnt <= fall_cnt + 3'd1;
  end
  assign warm = (fall_cnt == 3'd4);

  // R2
  always_comb begin
    if (!arst_ni) begin
      in_reset_quiet_chk: assert (!out_en_o && full_clk_o == '0 && half_clk_o == '0);
    end
  end

  // R3 R4
  enable_delay_chk: assert property (@(negedge clk_sel) disable iff (!arst_ni)
    warm |-> out_en_o == $past(hold_ni, cfo_pkg::SYNC_STAGES));

  // R5
  half_starts_high_chk: assert property (@(posedge clk_sel) disable iff (!arst_ni)
    $rose(out_en_o) ##1 out_en_o |-> half_clk_o[0]);

  // R6
  half_toggles_chk: assert property (@(posedge clk_sel) disable iff (!arst_ni)
    out_en_o && $past(out_en_o) |-> half_clk_o[0] != $past(half_clk_o[0]));

  // R8
  always_comb begin
    banks_matched_chk: assert (half_clk_o == {N_HALF{half_clk_o[0]}});
  end
endmodule

bind clk_fanout_ctl clk_fanout_ctl_chk #(.N_FULL(N_FULL), .N_HALF(N_HALF)) chk_i (
  .clk_sel    (clk_sel),
  .arst_ni    (arst_ni),
  .hold_ni    (hold_ni),
  .out_en_o   (out_en_o),
  .full_clk_o (full_clk_o),
  .half_clk_o (half_clk_o)
);

// File: tb/clk_fanout_ctl_tb_top.sv
`timescale 1ns/100ps
module clk_fanout_ctl_tb_top;
  localparam int NF = 10;
  localparam int NH = 10;
  localparam int NVEC = 20;
  // each entry: {hold_ni driven after this falling edge, enable expected at it}
  localparam logic [1:0] VEC [NVEC] = '{
    2'b11, 2'b11, 2'b01, 2'b01, 2'b01, 2'b01, 2'b00, 2'b00, 2'b10, 2'b10,
    2'b10, 2'b10, 2'b11, 2'b01, 2'b11, 2'b11, 2'b11, 2'b10, 2'b11, 2'b11};

  logic diff_clk, se_clk, src_sel, arst_n, hold_n;
  logic out_en;
  logic [NF-1:0] full_o;
  logic [NH-1:0] half_o;
  logic ref_clk;
  int total, bad;
  bit done;

  clk_fanout_ctl #(.N_FULL(NF), .N_HALF(NH)) dut_i (
    .diff_clk_i (diff_clk),
    .se_clk_i   (se_clk),
    .src_sel_i  (src_sel),
    .arst_ni    (arst_n),
    .hold_ni    (hold_n),
    .out_en_o   (out_en),
    .full_clk_o (full_o),
    .half_clk_o (half_o)
  );

  // 100 MHz single-ended clock; the other source runs slower and off-grid
  initial se_clk = 1'b0;
  always #5 se_clk = ~se_clk;
  initial begin
    diff_clk = 1'b0;
    #0.5;
    forever #7 diff_clk = ~diff_clk;
  end
  assign ref_clk = src_sel ? diff_clk : se_clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic fall(input int n);
    for (int k = 0; k < n; k++) @(negedge ref_clk);
    #1;
  endtask

  task automatic rise();
    @(posedge ref_clk);
    #1;
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    total = 0; bad = 0; done = 0;
    arst_n = 1'b0; hold_n = 1'b1; src_sel = 1'b0;
    #33;
    check("R2 enable", {31'b0, out_en}, 32'd0);
    check("R2 full", {22'b0, full_o}, 32'd0);
    check("R2 half", {22'b0, half_o}, 32'd0);
    rise();
    check("R2 full at rise", {22'b0, full_o}, 32'd0);
    fall(1);
    #1 arst_n = 1'b1;
    // R4: enable comes up on the fourth falling edge after release
    fall(3);
    check("R4 still low", {31'b0, out_en}, 32'd0);
    fall(1);
    check("R4 up", {31'b0, out_en}, 32'd1);

    // table walk: R3 R4 R9 R7
    for (int i = 0; i < NVEC; i++) begin
      fall(1);
      check("R3/R4/R9 enable", {31'b0, out_en}, {31'b0, VEC[i][0]});
      #1 hold_n = VEC[i][1];
      rise();
      check("R7 full bank", {22'b0, full_o}, VEC[i][0] ? 32'h3ff : 32'h0);
    end

    // R1: diff source selected
    src_sel = 1'b1;
    fall(6);
    for (int i = 0; i < 6; i++) begin
      @(edge diff_clk); #1;
      check("R1 diff source", {22'b0, full_o}, diff_clk ? 32'h3ff : 32'h0);
    end
    // R1: single-ended source selected
    src_sel = 1'b0;
    fall(6);
    for (int i = 0; i < 6; i++) begin
      @(edge se_clk); #1;
      check("R1 se source", {22'b0, full_o}, se_clk ? 32'h3ff : 32'h0);
    end

    // R3: hold, then outputs stay low through rising edges
    #1 hold_n = 1'b0;
    fall(6);
    check("R3 enable low", {31'b0, out_en}, 32'd0);
    rise();
    check("R3 full low", {22'b0, full_o}, 32'd0);
    check("R3 half low", {22'b0, half_o}, 32'd0);
    fall(1);
    #1 hold_n = 1'b1;
    fall(3);
    check("R4 held", {31'b0, out_en}, 32'd0);
    fall(1);
    check("R4 released", {31'b0, out_en}, 32'd1);
    check("R5 half low before first rise", {22'b0, half_o}, 32'd0);
    rise();
    check("R5 first half phase high", {22'b0, half_o}, 32'h3ff);
    check("R5 full aligned", {22'b0, full_o}, 32'h3ff);
    fall(1);
    check("R6 half holds over low phase", {22'b0, half_o}, 32'h3ff);
    for (int i = 0; i < 6; i++) begin
      rise();
      check("R6 R8 half toggle", {22'b0, half_o}, (i % 2 == 0) ? 32'h0 : 32'h3ff);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule